// File: doc/BRIEF.md
# Peak-Driven Automatic Gain Controller

This block watches a stream of signed audio samples and adjusts a gain word so that the loudest sample in each measurement window settles just above four-fifths of full scale. Over a fixed window of valid samples it keeps the largest magnitude. When the window closes, it compares that peak against three thresholds, makes one gain decision and clears the peak.

A peak near clipping pulls the gain down in a large step. A moderately high peak pulls it down in a small step. A peak below the target window asks for a small step up. A narrow dead band between the two lower thresholds leaves the gain alone. Two external inputs, hold and noise gate, block upward steps only. The gain word has an integer part and three fractional bits, and it saturates at limits that the integrating logic supplies.

A status byte reports the fractional gain bits, the decision flags from the latest window and the live hold and noise states. The multiplier that applies the gain and the logic that detects noise sit outside this block.

Top module: `agc_peak_ctrl`

## Requirements
- R1: The peak is the largest magnitude among exactly WIN_LEN samples accepted with `sample_valid` high. Samples presented with `sample_valid` low are ignored. The decision is taken on the clock edge that accepts the last sample of the window, `update_pulse` is high for the following cycle, and the next window starts from a peak of zero.
- R2: If the peak is above 90% of full scale (above 29491 for 16-bit samples), the gain drops by FAST_STEP (8) fractional units. Status bit 2 (fast decrement) and bit 3 (decrement) are set, and bit 4 is clear.
- R3: If the peak is above 81.25% of full scale (above 26624) but not above 90%, the gain drops by one unit. Status bit 3 is set, and bits 2 and 4 are clear.
- R4: If the peak is below 80% of full scale (below 26215), status bit 4 (increment) is set. The gain rises by one unit unless `hold_in` or `noise_in` is high at the decision.
- R5: If the peak is between 80% and 81.25% inclusive (26215 to 26624), the gain is unchanged and status bits 4, 3 and 2 are all clear.
- R6: Status bit 1 shows `hold_in` and status bit 0 shows `noise_in`, each registered one clock later.
- R7: The gain never rises above `gain_max` or falls below `gain_min`. A step that would pass a limit stops at that limit.
- R8: Status bits 7:5 always equal the three fractional bits of the gain, gain[2:0].
- R9: While reset is active, the gain loads `gain_init`, status bits 4:0 clear and the peak and sample count clear.
- R10: The most negative sample value counts as a magnitude of full scale.
- R11: Between decisions the gain does not change, and the decision flags keep the values from the last decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Marks `sample` as a valid audio sample |
| sample | input | SAMPLE_W | Signed audio sample |
| hold_in | input | 1 | Gain hold request; blocks upward steps |
| noise_in | input | 1 | Noise gate active; blocks upward steps |
| gain_min | input | GAIN_W | Lower gain limit (3 fractional bits) |
| gain_max | input | GAIN_W | Upper gain limit (3 fractional bits) |
| gain_init | input | GAIN_W | Gain loaded during reset |
| gain | output | GAIN_W | Current gain, integer part above three fractional bits |
| status | output | 8 | {gain[2:0], inc, dec, fast_dec, hold, noise} |
| update_pulse | output | 1 | High for one cycle after each window decision |

## Verification
On every cycle the assertions check several properties. The gain stays still outside decisions. It stays within its limits after a decision. It never rises while hold or noise is reported. A fast decrement always carries the decrement flag, increment and decrement are never flagged together, and a decision with no flags leaves the gain as it was. Only the bench scenarios can show that the threshold edges fall on the right sample values, that each step has the right size, that the peak is cleared between windows, that invalid samples are ignored and that saturation stops at each limit. They do this by comparing every decision against a model queue.

// File: rtl/agc_peak_ctrl.sv
module agc_peak_ctrl #(
  parameter int SAMPLE_W  = 16,
  parameter int WIN_LEN   = 256,
  parameter int GAIN_W    = 8,
  parameter int FAST_STEP = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       hold_in,
  input  logic                       noise_in,
  input  logic [GAIN_W-1:0]          gain_min,
  input  logic [GAIN_W-1:0]          gain_max,
  input  logic [GAIN_W-1:0]          gain_init,
  output logic [GAIN_W-1:0]          gain,
  output logic [7:0]                 status,
  output logic                       update_pulse
);

  localparam int     CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam longint FS    = longint'(1) << (SAMPLE_W - 1);
  localparam logic [SAMPLE_W-1:0] TH_FAST = SAMPLE_W'((FS * 9) / 10);
  localparam logic [SAMPLE_W-1:0] TH_DEC  = SAMPLE_W'((FS * 13) / 16);
  localparam logic [SAMPLE_W-1:0] TH_INC  = SAMPLE_W'((FS * 4 + 4) / 5);
  localparam logic [CNT_W-1:0]    LAST    = CNT_W'(WIN_LEN - 1);

  logic [SAMPLE_W-1:0] peak, mag, peak_nx;
  logic [CNT_W-1:0]    cnt;
  logic                inc_q, dec_q, fast_q, hold_q, noise_q;
  logic                last, is_fast, is_dec, is_inc;
  logic [GAIN_W:0]     step_dn, floor_w;
  logic [GAIN_W-1:0]   gain_dn, gain_up, gain_nx;

  assign mag     = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
  assign peak_nx = (mag > peak) ? mag : peak;
  assign last    = sample_valid && (cnt == LAST);

  assign is_fast = peak_nx > TH_FAST;
  assign is_dec  = peak_nx > TH_DEC;
  assign is_inc  = peak_nx < TH_INC;

  assign step_dn = is_fast ? (GAIN_W+1)'(FAST_STEP) : (GAIN_W+1)'(1);
  assign floor_w = {1'b0, gain_min} + step_dn;
  assign gain_dn = ({1'b0, gain} < floor_w) ? gain_min : GAIN_W'({1'b0, gain} - step_dn);
  assign gain_up = (gain >= gain_max) ? gain_max : gain + 1'b1;

  always_comb begin
    gain_nx = gain;
    if (is_dec)
      gain_nx = gain_dn;
    else if (is_inc && !hold_in && !noise_in)
      gain_nx = gain_up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain         <= gain_init;
      peak         <= '0;
      cnt          <= '0;
      inc_q        <= 1'b0;
      dec_q        <= 1'b0;
      fast_q       <= 1'b0;
      hold_q       <= 1'b0;
      noise_q      <= 1'b0;
      update_pulse <= 1'b0;
    end else begin
      hold_q       <= hold_in;
      noise_q      <= noise_in;
      update_pulse <= last;
      if (last) begin
        gain   <= gain_nx;
        peak   <= '0;
        cnt    <= '0;
        inc_q  <= is_inc;
        dec_q  <= is_dec;
        fast_q <= is_fast;
      end else if (sample_valid) begin
        peak <= peak_nx;
        cnt  <= cnt + 1'b1;
      end
    end
  end

  assign status = {gain[2:0], inc_q, dec_q, fast_q, hold_q, noise_q};

  assert_fast_has_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[3]);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[4] && status[3]));

  assert_gain_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !update_pulse |-> $stable(gain));

  assert_deadband_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (update_pulse && !status[4] && !status[3]) |-> gain == $past(gain));

  assert_gain_limits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> (gain >= gain_min && gain <= gain_max));

  assert_hold_blocks_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (update_pulse && (status[1] || status[0])) |-> gain <= $past(gain));

endmodule

// File: tb/agc_peak_ctrl_tb.sv
module agc_peak_ctrl_tb;
  localparam int SW = 16, WL = 16, GW = 8;

  logic clk = 0, rst_n = 0, sample_valid = 0, hold_in = 0, noise_in = 0;
  logic signed [SW-1:0] sample = '0;
  logic [GW-1:0] gain_min = 8'd16, gain_max = 8'd200, gain_init = 8'd100;
  logic [GW-1:0] gain;
  logic [7:0] status;
  logic update_pulse;

  agc_peak_ctrl #(.SAMPLE_W(SW), .WIN_LEN(WL), .GAIN_W(GW), .FAST_STEP(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .hold_in(hold_in), .noise_in(noise_in), .gain_min(gain_min), .gain_max(gain_max),
    .gain_init(gain_init), .gain(gain), .status(status), .update_pulse(update_pulse));

  always #2 clk = ~clk;

  int total = 0, fails = 0, pushed = 0, popped = 0;
  logic [GW-1:0] exp_gain;
  logic [GW+7:0] sb_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [GW-1:0] init);
    @(negedge clk);
    rst_n = 0; gain_init = init; exp_gain = init;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check(gain == init, "R9 gain after reset", gain, init);
    check(status[4:0] == 5'd0, "R9 flags after reset", status[4:0], 0);
    check(status[7:5] == init[2:0], "R8 frac after reset", status[7:5], init[2:0]);
  endtask

  // Driver: one window whose magnitude peak is pk; pushes the model result.
  task automatic run_window(input int pk, input bit neg, input bit hld, input bit nse,
                            input bit junk, input string tag);
    bit fast, dec, inc;
    int g;
    @(negedge clk);
    hold_in = hld; noise_in = nse;
    for (int i = 0; i < WL; i++) begin
      if (junk && i == 3) begin
        sample_valid = 0; sample = 16'sh8000;
        @(negedge clk);
      end
      sample_valid = 1;
      if (i == 7) sample = neg ? SW'(-pk) : SW'(pk);
      else sample = (i % 2) ? SW'(-(pk / 2)) : SW'(pk / 3);
      if (i == WL - 1) begin
        fast = pk > 29491; dec = pk > 26624; inc = pk < 26215;
        g = exp_gain;
        if (fast) g = (g < gain_min + 8) ? gain_min : g - 8;
        else if (dec) g = (g <= gain_min) ? gain_min : g - 1;
        else if (inc && !hld && !nse) g = (g >= gain_max) ? gain_max : g + 1;
        exp_gain = GW'(g);
        sb_q.push_back({exp_gain, exp_gain[2:0], inc, dec, fast, hld, nse});
        tag_q.push_back(tag);
        pushed++;
      end
      @(negedge clk);
    end
    sample_valid = 0; sample = '0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare each decision against the queue.
  always @(negedge clk) begin
    if (rst_n && update_pulse) begin
      if (sb_q.size() == 0) check(0, "R1 unexpected decision", 1, 0);
      else begin
        logic [GW+7:0] e;
        string t;
        e = sb_q.pop_front(); t = tag_q.pop_front(); popped++;
        check(gain == e[GW+7:8], {t, " gain"}, gain, e[GW+7:8]);
        check(status == e[7:0], {t, " status"}, status, e[7:0]);
      end
    end
  end

  initial begin
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    join_none

    do_reset(8'd100);
    run_window(1000, 0, 0, 0, 0, "R4 quiet up");
    run_window(1000, 1, 1, 0, 0, "R4 hold blocks");
    run_window(1000, 0, 0, 1, 0, "R4 noise blocks");
    run_window(27000, 1, 0, 0, 0, "R3 dec");
    run_window(30000, 0, 0, 0, 0, "R2 fast");
    run_window(26400, 0, 0, 0, 0, "R5 dead band");
    run_window(26215, 1, 0, 0, 0, "R5 low edge");
    run_window(26214, 0, 0, 0, 0, "R4 below edge");
    run_window(26624, 0, 0, 0, 0, "R5 high edge");
    run_window(26625, 1, 0, 0, 0, "R3 above edge");
    run_window(29491, 0, 0, 0, 0, "R3 fast edge");
    run_window(29492, 0, 0, 0, 0, "R2 fast above edge");
    run_window(32768, 1, 0, 0, 0, "R10 most negative");
    run_window(500, 0, 0, 0, 0, "R1 peak cleared");
    run_window(1000, 0, 0, 0, 1, "R1 invalid ignored");
    for (int k = 0; k < 10; k++) run_window(31000, 0, 0, 0, 0, "R7 min sat");

    // R6 live hold/noise flags
    @(negedge clk); hold_in = 1; noise_in = 0;
    @(negedge clk);
    check(status[1:0] == 2'b10, "R6 hold flag", status[1:0], 2);
    hold_in = 0; noise_in = 1;
    @(negedge clk);
    check(status[1:0] == 2'b01, "R6 noise flag", status[1:0], 1);
    noise_in = 0;
    // R11 flags persist between decisions
    check(status[4:2] == 3'b011, "R11 flags held", status[4:2], 3);
    @(negedge clk);

    do_reset(8'd198);
    for (int k = 0; k < 4; k++) run_window(2000, 0, 0, 0, 0, "R7 max sat");

    repeat (4) @(negedge clk);
    check(pushed == popped, "R1 decision count", popped, pushed);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule